// File: doc/BRIEF.md
# Noise-Aware Bus Expansion Encoder and Decoder

This block carries an M-bit on-chip data word across a package boundary as an N-bit code word. The code words are chosen so that no change from one word to the next switches too many pins at once, and so that no pin is pushed the wrong way by coupling from the pins beside it. The transmit side keeps the last word it sent as its state. For each new data value it sends one of the legal next words. The receive side keeps the last word it received. It turns each new word back into data by ranking that word among the legal next words of the previous one.

Legality is judged pin by pin. Each pin's change is rated +1 (rising), 0 (static) or -1 (falling). Each pin is a victim of its two nearest neighbours (weight K_NEAR) and its two second neighbours (weight K_FAR). The usable code set is found when the design is elaborated. It starts from all 2^N words and repeatedly removes every word that has fewer than 2^M legal successors left in the set. What remains is closed, and every word in it has at least 2^M legal exits. Both sides start from the all-zero word, which must belong to the set for the chosen parameters.

Top module: `nbx_codec`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `code` and `out_data` are zero, and `code_valid` and `out_valid` are low. Both the transmit state and the receive state are the all-zero word.
- R2: Between any two consecutive transmitted code words, at most SW_MAX pins change (default 3).
- R3: Take a pin that rises or falls between consecutive words. Add K_NEAR times the changes of its nearest neighbours and K_FAR times the changes of its second neighbours; a missing neighbour counts 0. This sum must be greater than DYN_LIM for a rising pin, and less than -DYN_LIM for a falling pin. Defaults: K_NEAR=2, K_FAR=1, DYN_LIM=-3.
- R4: For a pin that is static between consecutive words, the same weighted sum must lie strictly between -GLITCH_LIM and +GLITCH_LIM (default 3).
- R5: When `in_valid` is high with data value j, the next clock edge sets `code_valid` high. That edge also sets `code` to the j-th word, counting from zero in ascending numeric order, of all words in the usable set that are legal successors (R2–R4) of the previous code word.
- R6: When `in_valid` is low, `code_valid` goes low on the next edge and `code` keeps its previous value.
- R7: When `rx_valid` is high, the next edge sets `out_valid` high. That edge also sets `out_data` to the number of usable legal successors of the previously received word that are numerically below `rx_code`. `rx_code` then becomes the new receive state. When `code` is looped back to the receive port, `out_data` equals the transmitted data two cycles after `in_valid`.
- R8: When `rx_valid` is low, `rx_code` is ignored: `out_valid` goes low, `out_data` holds, and the receive state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data word present for encoding |
| in_data | input | M_BITS | Data word to encode |
| code_valid | output | 1 | A new code word was sent this cycle |
| code | output | N_BITS | Code word driven on the pins |
| rx_valid | input | 1 | Received code word present |
| rx_code | input | N_BITS | Received code word |
| out_valid | output | 1 | Decoded data present |
| out_data | output | M_BITS | Decoded data word |

## Verification
The transmit and receive sides can act in the same cycle. The bench loops `code` back into `rx_code` and issues a new `in_valid` on most cycles, so each edge encodes one word while it decodes the one sent a cycle earlier. Every transmitted word is judged against the bench's own legality rules and expected successor. Every decoded word must equal the data sent two cycles before. Gaps in `in_valid` check that both state registers hold while idle, and a reset in mid-stream checks that both sides return to the zero word together.

// File: rtl/nbx_codec.sv
module nbx_codec #(
  parameter int M_BITS     = 2,
  parameter int N_BITS     = 4,
  parameter int SW_MAX     = 3,
  parameter int K_NEAR     = 2,
  parameter int K_FAR      = 1,
  parameter int DYN_LIM    = -3,
  parameter int GLITCH_LIM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [M_BITS-1:0] in_data,
  output logic              code_valid,
  output logic [N_BITS-1:0] code,
  input  logic              rx_valid,
  input  logic [N_BITS-1:0] rx_code,
  output logic              out_valid,
  output logic [M_BITS-1:0] out_data
);
  localparam int NWORDS = 1 << N_BITS;
  localparam int NDATA  = 1 << M_BITS;

  function automatic bit pair_ok(input logic [N_BITS-1:0] a, input logic [N_BITS-1:0] b);
    int tr [N_BITS+4];
    int sw;
    int c;
    bit ok;
    ok = 1'b1;
    sw = 0;
    for (int i = 0; i < N_BITS + 4; i++) tr[i] = 0;
    for (int i = 0; i < N_BITS; i++) begin
      tr[i+2] = int'(b[i]) - int'(a[i]);
      if (tr[i+2] != 0) sw++;
    end
    if (sw > SW_MAX) ok = 1'b0;
    for (int i = 0; i < N_BITS; i++) begin
      c = K_NEAR * (tr[i+1] + tr[i+3]) + K_FAR * (tr[i] + tr[i+4]);
      if (tr[i+2] == 1 && !(c > DYN_LIM)) ok = 1'b0;
      if (tr[i+2] == -1 && !(c < -DYN_LIM)) ok = 1'b0;
      if (tr[i+2] == 0 && !(c > -GLITCH_LIM && c < GLITCH_LIM)) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [NWORDS-1:0] usable_set();
    logic [NWORDS-1:0] s;
    int cnt;
    s = '1;
    for (int it = 0; it < NWORDS; it++) begin
      for (int a = 0; a < NWORDS; a++) begin
        if (s[a]) begin
          cnt = 0;
          for (int b = 0; b < NWORDS; b++)
            if (s[b] && pair_ok(N_BITS'(a), N_BITS'(b))) cnt++;
          if (cnt < NDATA) s[a] = 1'b0;
        end
      end
    end
    return s;
  endfunction

  localparam logic [NWORDS-1:0] IN_SET = usable_set();

  logic [N_BITS-1:0] enc_q, enc_next;
  logic [N_BITS-1:0] dec_q;
  logic [M_BITS-1:0] dec_rank;
  int                enc_cnt;
  int                dec_cnt;

  assign code = enc_q;

  always_comb begin
    enc_next = enc_q;
    enc_cnt  = 0;
    for (int w = 0; w < NWORDS; w++) begin
      if (IN_SET[w] && pair_ok(enc_q, N_BITS'(w))) begin
        if (enc_cnt == int'(in_data)) enc_next = N_BITS'(w);
        enc_cnt++;
      end
    end
  end

  always_comb begin
    dec_cnt = 0;
    for (int w = 0; w < NWORDS; w++)
      if (IN_SET[w] && N_BITS'(w) < rx_code && pair_ok(dec_q, N_BITS'(w))) dec_cnt++;
    dec_rank = M_BITS'(dec_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q      <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= in_valid;
      if (in_valid) enc_q <= enc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rx_valid;
      if (rx_valid) begin
        dec_q    <= rx_code;
        out_data <= dec_rank;
      end
    end
  end
endmodule

// File: rtl/nbx_codec_chk.sv
module nbx_codec_chk #(
  parameter int M_BITS     = 2,
  parameter int N_BITS     = 4,
  parameter int SW_MAX     = 3,
  parameter int K_NEAR     = 2,
  parameter int K_FAR      = 1,
  parameter int DYN_LIM    = -3,
  parameter int GLITCH_LIM = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              code_valid,
  input logic [N_BITS-1:0] code,
  input logic              rx_valid,
  input logic              out_valid,
  input logic [M_BITS-1:0] out_data
);
  function automatic int wsum(input logic [N_BITS-1:0] a, input logic [N_BITS-1:0] b, input int p);
    int s;
    s = 0;
    for (int k = 0; k < N_BITS; k++) begin
      if (k == p - 1 || k == p + 1) s += K_NEAR * (int'(b[k]) - int'(a[k]));
      if (k == p - 2 || k == p + 2) s += K_FAR * (int'(b[k]) - int'(a[k]));
    end
    return s;
  endfunction

  function automatic bit moving_ok(input logic [N_BITS-1:0] a, input logic [N_BITS-1:0] b);
    bit ok;
    ok = 1'b1;
    for (int p = 0; p < N_BITS; p++) begin
      if (!a[p] && b[p] && wsum(a, b, p) <= DYN_LIM) ok = 1'b0;
      if (a[p] && !b[p] && wsum(a, b, p) >= -DYN_LIM) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic bit quiet_ok(input logic [N_BITS-1:0] a, input logic [N_BITS-1:0] b);
    bit ok;
    ok = 1'b1;
    for (int p = 0; p < N_BITS; p++)
      if (a[p] == b[p] && (wsum(a, b, p) >= GLITCH_LIM || wsum(a, b, p) <= -GLITCH_LIM)) ok = 1'b0;
    return ok;
  endfunction

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (code == '0 && !code_valid && !out_valid && out_data == '0)); // R1
  AST_SWITCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(code ^ $past(code)) <= SW_MAX); // R2
  AST_MOVING_COUPLING: assert property (@(posedge clk) disable iff (!rst_n)
    moving_ok($past(code), code)); // R3
  AST_STATIC_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_ok($past(code), code)); // R4
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> code_valid); // R5
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!code_valid && $stable(code))); // R6
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> out_valid); // R7
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!out_valid && $stable(out_data))); // R8
endmodule

bind nbx_codec nbx_codec_chk #(
  .M_BITS(M_BITS), .N_BITS(N_BITS), .SW_MAX(SW_MAX), .K_NEAR(K_NEAR),
  .K_FAR(K_FAR), .DYN_LIM(DYN_LIM), .GLITCH_LIM(GLITCH_LIM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code_valid(code_valid),
  .code(code), .rx_valid(rx_valid), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/nbx_codec_tb_top.sv
module nbx_codec_tb_top;
  localparam int M  = 2;
  localparam int N  = 4;
  localparam int NW = 1 << N;
  localparam int ND = 1 << M;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [M-1:0] in_data = '0;
  logic         code_valid;
  logic [N-1:0] code;
  logic         out_valid;
  logic [M-1:0] out_data;

  always #5 clk = ~clk;

  nbx_codec #(.M_BITS(M), .N_BITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .code_valid(code_valid), .code(code), .rx_valid(code_valid), .rx_code(code),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit in_s [NW];

  logic [N-1:0] model_prev;
  logic [N-1:0] pin_last;
  logic [M-1:0] last_out;
  bit           v1, v2;
  logic [M-1:0] d1, d2;
  logic [N-1:0] c1;

  function automatic int tdir(input logic [N-1:0] a, input logic [N-1:0] b, input int p);
    if (p < 0 || p >= N) return 0;
    return int'(b[p]) - int'(a[p]);
  endfunction

  function automatic bit legal(input logic [N-1:0] a, input logic [N-1:0] b);
    int sw, s, t;
    sw = 0;
    for (int p = 0; p < N; p++) if (a[p] != b[p]) sw++;
    if (sw > 3) return 1'b0;                       // R2
    for (int p = 0; p < N; p++) begin
      s = 2 * (tdir(a, b, p - 1) + tdir(a, b, p + 1)) + (tdir(a, b, p - 2) + tdir(a, b, p + 2));
      t = tdir(a, b, p);
      if (t == 1 && s <= -3) return 1'b0;          // R3
      if (t == -1 && s >= 3) return 1'b0;          // R3
      if (t == 0 && (s >= 3 || s <= -3)) return 1'b0; // R4
    end
    return 1'b1;
  endfunction

  function automatic logic [N-1:0] succ(input logic [N-1:0] cur, input int j);
    int k;
    k = 0;
    for (int w = 0; w < NW; w++)
      if (in_s[w] && legal(cur, N'(w))) begin
        if (k == j) return N'(w);
        k++;
      end
    return cur;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [M-1:0] d);
    @(negedge clk);
    chk(code_valid == v1, "R5/R6 code_valid", int'(code_valid), int'(v1));
    if (v1) begin
      chk(code == c1, "R5 code word", int'(code), int'(c1));
      chk(legal(pin_last, code), "R2/R3/R4 transition", int'(code), int'(pin_last));
      pin_last = code;
    end else
      chk(code == pin_last, "R6 code hold", int'(code), int'(pin_last));
    chk(out_valid == v2, "R7/R8 out_valid", int'(out_valid), int'(v2));
    if (v2) begin
      chk(out_data == d2, "R7 decoded data", int'(out_data), int'(d2));
      last_out = out_data;
    end else
      chk(out_data == last_out, "R8 out hold", int'(out_data), int'(last_out));
    v2 = v1; d2 = d1;
    v1 = v;  d1 = d;
    if (v) begin
      c1 = succ(model_prev, int'(d));
      model_prev = c1;
    end
    in_valid = v;
    in_data  = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk(code == '0 && !code_valid, "R1 code reset", int'(code), 0);
    chk(out_data == '0 && !out_valid, "R1 out reset", int'(out_data), 0);
    rst_n = 1'b1;
    model_prev = '0; pin_last = '0; last_out = '0;
    v1 = 1'b0; v2 = 1'b0; d1 = '0; d2 = '0; c1 = '0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    for (int w = 0; w < NW; w++) in_s[w] = 1'b1;
    for (int it = 0; it < NW; it++)
      for (int a = 0; a < NW; a++)
        if (in_s[a]) begin
          int cnt;
          cnt = 0;
          for (int b = 0; b < NW; b++) if (in_s[b] && legal(N'(a), N'(b))) cnt++;
          if (cnt < ND) in_s[a] = 1'b0;
        end
    r = $urandom(32'h5eed_1234);
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1, M'(ND - 1));   // R5 top index every cycle
    for (int i = 0; i < 20; i++) step(1'b1, '0);            // R5 lowest index
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, M'($urandom));
    for (int i = 0; i < 5; i++) step(1'b0, M'($urandom));  // R6 R8 idle gap
    for (int i = 0; i < 50; i++) step(1'b1, M'($urandom));
    do_reset();                                              // R1 mid-stream
    for (int i = 0; i < 2000; i++) step(($urandom % 3) != 0, M'($urandom));
    step(1'b0, '0);
    step(1'b0, '0);
    step(1'b0, '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule